// File: doc/BRIEF.md
# Serial Port Configuration Glue

This block sits between a byte-wide host bus and a 16550-style UART and replaces the set of mechanical configuration switches that such a port used to carry. It holds a configuration register in a separate "hidden" address space. That register selects whether the port is the system console, which of four interrupt levels the port uses, whether hardware handshake circuitry is fitted, which baud generator clock runs, and whether the modem control inputs of the UART are forced active. The standard address space shows a subset of those settings back to software.

The standard space has two registers. The identification register shows the console bit. Writing any value to it fires a reset pulse of fixed length toward the UART. The status/control register holds an interrupt enable and shows the raw UART interrupt, the selected level and two of the hidden settings. The block drives a one-hot interrupt vector on the selected level, a baud clock select, and the four modem input lines of the UART. Those lines are either held high or copied from the connector.

Top module: `serial_cfg_glue`

## Requirements
- R1: After a hard reset, the hidden register at offset 0x01 reads 0x21, the interrupt enable is 0, the reset pulse output is low, the baud select is low and the modem lines are all high.
- R2: A read of standard offset 0x01 returns the console-select bit in bit 7 and zero in bits 6:0.
- R3: Any write to standard offset 0x01 drives `uart_rst` high from the next cycle for exactly PULSE_CYCLES cycles.
- R4: A further write to standard offset 0x01 while the pulse runs restarts it, so the pulse ends PULSE_CYCLES cycles after the last write.
- R5: A read of standard offset 0x03 returns {enable, UART request, level[1:0], 0, 0, handshake-present, high-speed} from bit 7 down to bit 0.
- R6: A write to standard offset 0x03 changes only the enable, which takes bit 7 of the write data. The other bits written have no effect.
- R7: The request bit in offset 0x03 follows `uart_irq` whether or not the enable is set.
- R8: `irq_lvl_out` is zero unless the enable and `uart_irq` are both 1. When both are 1 it is one-hot, with level code 00 to bit 0 (level 3), 01 to bit 1 (level 4), 10 to bit 2 (level 5) and 11 to bit 3 (level 6).
- R9: `soft_rst` clears the interrupt enable and leaves the hidden register unchanged. When a soft reset and a control write come in the same cycle, the soft reset wins.
- R10: The hidden register at offset 0x01 (hid_sel high) is written in full. It reads back as bit 7 console, bits 5:4 level, bit 2 handshake present, bit 1 high speed and bit 0 remote enable, with bits 6 and 3 reading 0.
- R11: `baud_fast` equals the high-speed bit of the hidden register.
- R12: When the remote-enable bit is 1, `uart_modem` is 4'b1111. When it is 0, `uart_modem` equals `conn_modem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard (power-up) reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset, clears the interrupt enable |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| hid_sel | input | 1 | Selects the hidden address space |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the offset presented, combinational |
| uart_irq | input | 1 | Interrupt output of the UART |
| irq_lvl_out | output | 4 | One-hot interrupt on levels 3 to 6 |
| uart_rst | output | 1 | Reset pulse toward the UART |
| baud_fast | output | 1 | Selects the faster baud generator clock |
| conn_modem | input | 4 | Modem control levels from the connector |
| uart_modem | output | 4 | Modem control inputs driven to the UART |

## Verification
The hardest case to reach is a reset pulse restarted partway through, because the extension only shows up as the exact cycle on which `uart_rst` falls. The stimulus writes the identification register, lets the pulse run for a few cycles and writes again. It then counts cycles to the falling edge. Soft reset colliding with a control write, and every level code paired with a raw interrupt and a masked interrupt, are also driven on purpose. A random phase then mixes all of these, and the cycle model is compared on every clock throughout.

// File: rtl/serial_cfg_glue.sv
`timescale 1ns/1ps
module serial_cfg_glue #(
  parameter int PULSE_CYCLES = 16,
  parameter int ADDR_W       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              hid_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  input  logic              uart_irq,
  output logic [3:0]        irq_lvl_out,
  output logic              uart_rst,
  output logic              baud_fast,
  input  logic [3:0]        conn_modem,
  output logic [3:0]        uart_modem
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFS_ID  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(3);
  localparam logic [7:0] CFG_DEFAULT = 8'h21;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic             console_q, hh_q, hs_q, ren_q, ie_q;
  logic [1:0]       lvl_q;
  logic [CNT_W-1:0] cnt_q;

  wire wr_id  = bus_wr & ~hid_sel & (bus_addr == OFS_ID);
  wire wr_ctl = bus_wr & ~hid_sel & (bus_addr == OFS_CTL);
  wire wr_cfg = bus_wr &  hid_sel & (bus_addr == OFS_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      console_q <= CFG_DEFAULT[7];
      lvl_q     <= CFG_DEFAULT[5:4];
      hh_q      <= CFG_DEFAULT[2];
      hs_q      <= CFG_DEFAULT[1];
      ren_q     <= CFG_DEFAULT[0];
    end else if (wr_cfg) begin
      console_q <= bus_wdata[7];
      lvl_q     <= bus_wdata[5:4];
      hh_q      <= bus_wdata[2];
      hs_q      <= bus_wdata[1];
      ren_q     <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ie_q <= 1'b0;
    else if (soft_rst) ie_q <= 1'b0;
    else if (wr_ctl)   ie_q <= bus_wdata[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (wr_id)        cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign uart_rst    = (cnt_q != '0);
  assign baud_fast   = hs_q;
  assign uart_modem  = ren_q ? 4'b1111 : conn_modem;
  assign irq_lvl_out = (ie_q & uart_irq) ? (4'b0001 << lvl_q) : 4'b0000;

  always_comb begin
    rd_data = 8'h00;
    if (hid_sel) begin
      if (bus_addr == OFS_ID)
        rd_data = {console_q, 1'b0, lvl_q, 1'b0, hh_q, hs_q, ren_q};
    end else if (bus_addr == OFS_ID) begin
      rd_data = {console_q, 7'b0};
    end else if (bus_addr == OFS_CTL) begin
      rd_data = {ie_q, uart_irq, lvl_q, 2'b00, hh_q, hs_q};
    end
  end
endmodule

module serial_cfg_glue_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              hid_sel,
  input logic [7:0]        bus_wdata,
  input logic              uart_irq,
  input logic [3:0]        irq_lvl_out,
  input logic              uart_rst,
  input logic              baud_fast,
  input logic [3:0]        uart_modem
);
  wire id_write  = bus_wr && !hid_sel && (bus_addr == ADDR_W'(1));
  wire cfg_write = bus_wr &&  hid_sel && (bus_addr == ADDR_W'(1));

  assert_id_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    id_write |=> uart_rst);
  assert_no_early_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uart_rst) |-> !$past(id_write));
  assert_irq_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lvl_out));
  assert_irq_needs_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_out != 4'b0) |-> uart_irq);
  assert_soft_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (irq_lvl_out == 4'b0));
  assert_baud_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> (baud_fast == $past(bus_wdata[1])));
  assert_modem_force_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_write && bus_wdata[0]) |=> (uart_modem == 4'b1111));
endmodule

bind serial_cfg_glue serial_cfg_glue_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .hid_sel(hid_sel), .bus_wdata(bus_wdata),
  .uart_irq(uart_irq), .irq_lvl_out(irq_lvl_out), .uart_rst(uart_rst),
  .baud_fast(baud_fast), .uart_modem(uart_modem)
);

// File: tb/sim_serial_cfg_glue.sv
`timescale 1ns/1ps
module sim_serial_cfg_glue;
  localparam int PULSE = 16;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, bus_wr = 1'b0, hid_sel = 1'b0, uart_irq = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 8'h00;
  logic [3:0] conn_modem = 4'h0;
  logic [7:0] rd_data;
  logic [3:0] irq_lvl_out, uart_modem;
  logic uart_rst, baud_fast;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_cfg_glue #(.PULSE_CYCLES(PULSE), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .hid_sel(hid_sel), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .uart_irq(uart_irq), .irq_lvl_out(irq_lvl_out), .uart_rst(uart_rst),
    .baud_fast(baud_fast), .conn_modem(conn_modem), .uart_modem(uart_modem));

  // reference model state
  bit m_con, m_hh, m_hs, m_ren, m_ie;
  int m_lvl, m_cnt;

  task automatic m_defaults();
    m_con = 0; m_lvl = 2; m_hh = 0; m_hs = 0; m_ren = 1; m_ie = 0; m_cnt = 0;
  endtask

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    int v = 0;
    if (hid_sel) begin
      if (bus_addr == 1) v = m_con*128 + m_lvl*16 + m_hh*4 + m_hs*2 + m_ren;
    end else if (bus_addr == 1) v = m_con*128;
    else if (bus_addr == 3) v = m_ie*128 + uart_irq*64 + m_lvl*16 + m_hh*2 + m_hs;
    return v;
  endfunction

  function automatic string rd_tag();
    if (hid_sel) return "R10";
    if (bus_addr == 1) return "R2";
    return "R5";
  endfunction

  task automatic compare();
    if (!rst_n) m_defaults();
    chk(rd_tag(), rd_data, exp_rd());
    chk("R3", uart_rst, m_cnt > 0);
    chk("R8", irq_lvl_out, (m_ie && uart_irq) ? (1 << m_lvl) : 0);
    chk("R11", baud_fast, m_hs);
    chk("R12", uart_modem, m_ren ? 15 : conn_modem);
  endtask

  task automatic update();
    if (!rst_n) begin m_defaults(); return; end
    if (soft_rst) m_ie = 0;
    else if (bus_wr && !hid_sel && bus_addr == 3) m_ie = bus_wdata[7];
    if (bus_wr && hid_sel && bus_addr == 1) begin
      m_con = bus_wdata[7]; m_lvl = bus_wdata[5:4]; m_hh = bus_wdata[2];
      m_hs = bus_wdata[1]; m_ren = bus_wdata[0];
    end
    if (bus_wr && !hid_sel && bus_addr == 1) m_cnt = PULSE;
    else if (m_cnt > 0) m_cnt--;
  endtask

  // call at negedge with inputs already set; directed checks may run after #1
  task automatic tick();
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    bus_wr = 0; soft_rst = 0;
    for (int i = 0; i < n; i++) begin #1; tick(); end
  endtask

  task automatic wr(bit hid, int a, int d);
    hid_sel = hid; bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1;
    #1; tick();
    bus_wr = 0;
  endtask

  task automatic rd(bit hid, int a);
    hid_sel = hid; bus_addr = AW'(a); bus_wr = 0;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    m_defaults();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin #1; tick(); end
    rst_n = 1;
    // R1 reset state
    rd(1, 1); chk("R1", rd_data, 8'h21);
    chk("R1", uart_rst, 0); chk("R1", baud_fast, 0); chk("R1", uart_modem, 4'hF);
    tick();
    rd(0, 3); chk("R1", rd_data[7], 0); chk("R5", rd_data, 8'h20); tick();

    // R10 / R2 / R11 / R12
    wr(1, 1, 8'hFF);
    rd(1, 1); chk("R10", rd_data, 8'hB7); tick();
    rd(0, 1); chk("R2", rd_data, 8'h80); chk("R11", baud_fast, 1); tick();
    wr(1, 1, 8'h14);
    conn_modem = 4'b1010;
    rd(0, 3); chk("R5", rd_data, 8'h12); chk("R12", uart_modem, 4'b1010);
    chk("R11", baud_fast, 0); tick();
    rd(0, 1); chk("R2", rd_data, 8'h00); tick();

    // R6: only bit 7 of control is writable
    wr(0, 3, 8'h7F);
    rd(0, 3); chk("R6", rd_data, 8'h12); tick();
    wr(0, 3, 8'hFF);
    rd(0, 3); chk("R6", rd_data, 8'h92); tick();

    // R7: request follows UART regardless of enable
    wr(0, 3, 8'h00);
    uart_irq = 1;
    rd(0, 3); chk("R7", rd_data[6], 1); chk("R8", irq_lvl_out, 0); tick();
    uart_irq = 0;
    rd(0, 3); chk("R7", rd_data[6], 0); tick();

    // R8: each level code
    wr(0, 3, 8'h80);
    for (int l = 0; l < 4; l++) begin
      wr(1, 1, l * 16);
      uart_irq = 1;
      rd(0, 3); chk("R8", irq_lvl_out, 1 << l); tick();
      uart_irq = 0;
      rd(0, 3); chk("R8", irq_lvl_out, 0); tick();
    end

    // R9: soft reset beats a control write; hidden unchanged
    wr(1, 1, 8'hA6);
    hid_sel = 0; bus_addr = 3; bus_wdata = 8'h80; bus_wr = 1; soft_rst = 1;
    #1; tick();
    bus_wr = 0; soft_rst = 0; uart_irq = 1;
    rd(0, 3); chk("R9", rd_data[7], 0); chk("R9", irq_lvl_out, 0); tick();
    uart_irq = 0;
    rd(1, 1); chk("R9", rd_data, 8'hA6); tick();

    // R3: pulse length
    wr(0, 1, 8'h00);
    hi = 0;
    for (int i = 0; i < PULSE + 4; i++) begin
      rd(0, 0); if (uart_rst) hi++; tick();
    end
    chk("R3", hi, PULSE);

    // R4: restart during pulse
    wr(0, 1, 8'h5A);
    idle(5);
    wr(0, 1, 8'h00);
    for (int i = 0; i < PULSE - 1; i++) begin rd(0, 0); tick(); end
    rd(0, 0); chk("R4", uart_rst, 1); tick();
    rd(0, 0); chk("R4", uart_rst, 0); tick();

    // mixed random phase, compared every clock by the model
    for (int i = 0; i < 600; i++) begin
      int r = $urandom;
      hid_sel = r[0]; bus_addr = AW'(r[3:1] % 4);
      bus_wr = (r[7:4] == 0); bus_wdata = 8'($urandom);
      soft_rst = (r[11:8] == 0); uart_irq = r[12];
      conn_modem = r[16:13];
      #1; tick();
    end
    idle(PULSE + 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule